// File: doc/BRIEF.md
# TDM Slot Transmitter With Line Release

This block puts audio samples onto one shared time-division-multiplexed serial data line. The line carries a frame of 2, 4, 8 or 16 equal slots, and one slot holds one channel sample. The block runs on the bit clock. It starts each frame from a frame-sync pulse that is one bit clock wide. It tracks the current slot and bit position. During the contiguous run of slots it owns, it sends one sample per slot, most significant bit first. During every other slot it lets go of the line, so other sources can drive it. A fill option instead keeps the line driven low during the slots it does not own. Use that option when this device is the only source on the line.

Samples come in through a parallel valid/ready port. The block holds one sample in reserve. At the start of each owned slot, that reserved sample moves to the shifter. If no sample is waiting, the slot carries zeros. In master mode the block makes the frame-sync pulse itself, once per frame length, and ignores the external sync input. In slave mode it follows the external pulse. The slot width can be 16, 24 or 32 bits. Slot bits beyond the sample length are sent as zero.

Top module: `tdm_slot_tx`

## Requirements
- R1: While reset is active, sd_oe, sd_out and fsync_out are 0 and smp_ready is 1.
- R2: Until the first frame-sync pulse is sampled, sd_oe stays 0.
- R3: On the clock edge that samples a sync pulse, the position moves to slot 0, bit 0. This holds even in the middle of a frame. Each later edge advances one bit, and a frame lasts slots × width bit clocks.
- R4: cfg_slots_sel selects the slot count: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16.
- R5: cfg_width_sel selects the slot width: 0 gives 16 bits, 1 gives 24 bits, 2 or 3 give 32 bits.
- R6: The owned slots run from cfg_first_slot up to cfg_first_slot+cfg_own_count−1, clipped at the last slot. In an owned slot, sd_oe is 1 and bit b of the slot carries sample bit SAMPLE_W−1−b.
- R7: In an owned slot, every bit position b ≥ SAMPLE_W is sent as 0. A 16-bit slot therefore carries the upper 16 sample bits.
- R8: In a slot that is not owned, sd_oe is 0 when cfg_fill_idle is 0. When cfg_fill_idle is 1, sd_oe is 1 and sd_out is 0.
- R9: sd_oe changes value only on the first bit of a slot.
- R10: Each owned slot consumes one sample, in arrival order. smp_ready is 1 exactly when no sample is waiting. An owned slot that starts with no sample waiting is sent as all zeros.
- R11: With cfg_master=1, fsync_out is a single-cycle pulse every slots × width cycles. The first pulse comes at cycle frame−1 after reset release. The block aligns to this pulse, and fsync_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate the frame sync internally |
| cfg_slots_sel | input | 2 | Slot count select (R4) |
| cfg_width_sel | input | 2 | Slot width select (R5) |
| cfg_first_slot | input | 4 | First owned slot |
| cfg_own_count | input | 5 | Number of owned slots (0 to 16) |
| cfg_fill_idle | input | 1 | Drive unowned slots low instead of releasing |
| fsync_in | input | 1 | External frame-sync pulse (slave mode) |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | SAMPLE_W | Sample value |
| smp_ready | output | 1 | Reserve slot empty |
| fsync_out | output | 1 | Generated frame-sync pulse |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Data line driver enable |

## Verification
Fixed-seed random configurations cover every slot count and width. They cover owned runs that start anywhere and runs clipped at the frame end, in both master and slave mode. Each bit is compared with a position-based model, which separates errors in slot decoding from errors in bit ordering. Directed cases are added for four behaviours:
- a 16-bit slot, which shows truncation;
- a 32-bit slot, which shows the zero padding;
- a sample stream that is always absent, which shows the zero-fill on underrun;
- a sync pulse that arrives in mid-frame, which shows the restart.

The random cases withhold the valid signal at times, so samples run short in some slots. These checks show that samples are consumed in order, one per owned slot, and are neither repeated nor skipped.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int MAX_SLOTS = 16;
  localparam int MAX_BITS  = 32;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int BIT_W     = $clog2(MAX_BITS);
  localparam int FRAME_W   = $clog2(MAX_SLOTS * MAX_BITS);

  typedef enum logic [1:0] {
    WID_16  = 2'd0,
    WID_24  = 2'd1,
    WID_32  = 2'd2,
    WID_32X = 2'd3
  } slot_width_e;

  function automatic logic [BIT_W:0] width_bits(input logic [1:0] sel);
    case (slot_width_e'(sel))
      WID_16:  return (BIT_W+1)'(16);
      WID_24:  return (BIT_W+1)'(24);
      default: return (BIT_W+1)'(32);
    endcase
  endfunction

  function automatic logic [SLOT_W:0] slot_total(input logic [1:0] sel);
    return (SLOT_W+1)'(2) << sel;
  endfunction

  function automatic logic slot_owned(input logic [SLOT_W-1:0] slot,
                                      input logic [SLOT_W-1:0] first,
                                      input logic [SLOT_W:0]   count,
                                      input logic [SLOT_W:0]   total);
    logic [SLOT_W:0] rel;
    rel = {1'b0, slot} - {1'b0, first};
    return ({1'b0, slot} < total) && (slot >= first) && (rel < count);
  endfunction
endpackage

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
  import tdm_tx_pkg::*;
#(
  parameter int CNT_W = FRAME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] frame_last,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                     cnt_d = '0;
    else if (cnt_q >= frame_last) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse = en && (cnt_q == frame_last);
endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
  import tdm_tx_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int BW = BIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_pulse,
  input  logic [BW-1:0] bit_last,
  input  logic [SW-1:0] slot_last,
  output logic          run_q,
  output logic [BW-1:0] bit_q,
  output logic [SW-1:0] slot_q,
  output logic          run_d,
  output logic [BW-1:0] bit_d,
  output logic [SW-1:0] slot_d
);
  always_comb begin
    run_d  = run_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    if (sync_pulse) begin
      run_d  = 1'b1;
      bit_d  = '0;
      slot_d = '0;
    end else if (run_q) begin
      if (bit_q >= bit_last) begin
        bit_d  = '0;
        slot_d = (slot_q >= slot_last) ? '0 : slot_q + 1'b1;
      end else begin
        bit_d  = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/tdm_sample_stage.sv
module tdm_sample_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic [W-1:0] cur_q
);
  logic         full_q, full_d;
  logic [W-1:0] hold_q, hold_d, cur_d;
  logic         accept;

  assign in_ready = !full_q;
  assign accept   = in_valid && in_ready;

  always_comb begin
    hold_d = accept ? in_data : hold_q;
    full_d = full_q ? !take : in_valid;
    cur_d  = cur_q;
    if (take) cur_d = full_q ? hold_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
      cur_q  <= '0;
    end else begin
      full_q <= full_d;
      hold_q <= hold_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic [1:0]          cfg_slots_sel,
  input  logic [1:0]          cfg_width_sel,
  input  logic [3:0]          cfg_first_slot,
  input  logic [4:0]          cfg_own_count,
  input  logic                cfg_fill_idle,
  input  logic                fsync_in,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_ready,
  output logic                fsync_out,
  output logic                sd_out,
  output logic                sd_oe
);
  localparam int SW = SLOT_W;
  localparam int BW = BIT_W;
  localparam int FW = FRAME_W;

  logic [BW:0]   bits_per_slot;
  logic [SW:0]   slots_per_frame;
  logic [FW:0]   frame_len;
  logic [FW-1:0] frame_last;
  logic [BW-1:0] bit_last;
  logic [SW-1:0] slot_last;
  logic          gen_pulse, sync_sel;
  logic          run_q, run_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          own_now, own_next, take;
  logic [SAMPLE_W-1:0] cur_q, shifted;
  logic          in_sample;

  always_comb begin
    bits_per_slot   = width_bits(cfg_width_sel);
    slots_per_frame = slot_total(cfg_slots_sel);
    frame_len       = (FW+1)'(bits_per_slot) * (FW+1)'(slots_per_frame);
    frame_last      = FW'(frame_len - 1'b1);
    bit_last        = BW'(bits_per_slot - 1'b1);
    slot_last       = SW'(slots_per_frame - 1'b1);
  end

  tdm_frame_gen #(.CNT_W(FW)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_master),
    .frame_last (frame_last),
    .pulse      (gen_pulse)
  );

  assign sync_sel  = cfg_master ? gen_pulse : fsync_in;
  assign fsync_out = gen_pulse;

  tdm_slot_counter #(.SW(SW), .BW(BW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_sel),
    .bit_last   (bit_last),
    .slot_last  (slot_last),
    .run_q      (run_q),
    .bit_q      (bit_q),
    .slot_q     (slot_q),
    .run_d      (run_d),
    .bit_d      (bit_d),
    .slot_d     (slot_d)
  );

  assign own_now  = slot_owned(slot_q, cfg_first_slot, cfg_own_count, slots_per_frame);
  assign own_next = slot_owned(slot_d, cfg_first_slot, cfg_own_count, slots_per_frame);
  assign take     = run_d && (bit_d == '0) && own_next;

  tdm_sample_stage #(.W(SAMPLE_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .in_ready (smp_ready),
    .take     (take),
    .cur_q    (cur_q)
  );

  assign shifted   = cur_q << bit_q;
  assign in_sample = int'(bit_q) < SAMPLE_W;

  assign sd_oe  = run_q && (own_now || cfg_fill_idle);
  assign sd_out = run_q && own_now && in_sample && shifted[SAMPLE_W-1];
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_sel,
  input logic             run_q,
  input logic [BIT_W-1:0] bit_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic             own_now,
  input logic             fsync_out,
  input logic             sd_out,
  input logic             sd_oe
);
  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sd_oe);

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_sel |=> (run_q && bit_q == '0 && slot_q == '0));

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bit_q) >= SAMPLE_W) |-> !sd_out);

  p_quiet_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);

  p_unowned_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && !own_now) |-> !sd_out);

  p_oe_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_oe) |-> (bit_q == '0));

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |=> !fsync_out);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_sel  (sync_sel),
  .run_q     (run_q),
  .bit_q     (bit_q),
  .slot_q    (slot_q),
  .own_now   (own_now),
  .fsync_out (fsync_out),
  .sd_out    (sd_out),
  .sd_oe     (sd_oe)
);

// File: tb/test_tdm_slot_tx.sv
`timescale 1ns/1ps
module test_tdm_slot_tx;
  localparam int SW = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_master, cfg_fill_idle, fsync_in, smp_valid;
  logic [1:0] cfg_slots_sel, cfg_width_sel;
  logic [3:0] cfg_first_slot;
  logic [4:0] cfg_own_count;
  logic [SW-1:0] smp_data;
  logic smp_ready, fsync_out, sd_out, sd_oe;

  tdm_slot_tx #(.SAMPLE_W(SW)) i_tdm_slot_tx (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .cfg_slots_sel(cfg_slots_sel), .cfg_width_sel(cfg_width_sel),
    .cfg_first_slot(cfg_first_slot), .cfg_own_count(cfg_own_count),
    .cfg_fill_idle(cfg_fill_idle), .fsync_in(fsync_in),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .fsync_out(fsync_out), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int W, N, L, valid_pct;
  logic [SW-1:0] q[$];
  logic [SW-1:0] cur_exp, pend_data;
  logic pend_hs;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_width(input int sel);
    return (sel == 0) ? 16 : (sel == 1) ? 24 : 32;
  endfunction

  function automatic bit own_exp(input int slot);
    return slot >= int'(cfg_first_slot) &&
           slot < int'(cfg_first_slot) + int'(cfg_own_count) && slot < N;
  endfunction

  // One bit clock: check position pos (or idle when pos < 0), then drive inputs.
  task automatic step(input bit fs, input int pos);
    int slot, b;
    bit own, exp_oe, exp_sd;
    string tag;
    @(negedge clk);
    if (pos >= 0) begin
      slot = pos / W;
      b    = pos % W;
      own  = own_exp(slot);
      if (own && b == 0) cur_exp = (q.size() > 0) ? q.pop_front() : '0;
      exp_oe = own || cfg_fill_idle;
      if (pos == 0)                  tag = "R3";
      else if (slot == N-1 && b == 0) tag = "R4";
      else if (b == W-1)              tag = "R5";
      else if (b == 0)                tag = "R9";
      else                            tag = "R8";
      chk(tag, 32'(sd_oe), 32'(exp_oe));
      exp_sd = own && (b < SW) && cur_exp[SW-1-((b < SW) ? b : 0)];
      if (exp_oe) begin
        if (own && b == 0)  tag = "R10";
        else if (b >= SW)   tag = "R7";
        else if (own)       tag = "R6";
        else                tag = "R8";
        chk(tag, 32'(sd_out), 32'(exp_sd));
      end
      if (cfg_master) chk("R11", 32'(fsync_out), 32'(pos == L-1));
    end else begin
      chk("R2", 32'(sd_oe), 32'd0);
    end
    if (pend_hs) q.push_back(pend_data);
    smp_valid = (($urandom % 100) < valid_pct);
    smp_data  = SW'($urandom);
    pend_hs   = smp_valid && smp_ready;
    pend_data = smp_data;
    fsync_in  = cfg_master ? 1'($urandom % 2) : fs;
  endtask

  task automatic run_frame(input int len);
    for (int i = 0; i < len; i++) step(i == len-1, i);
  endtask

  task automatic setup(input int ssel, input int wsel, input int first,
                       input int cnt, input bit fill, input bit master, input int vp);
    rst_n = 1'b0;
    smp_valid = 1'b0; smp_data = '0; fsync_in = 1'b0;
    cfg_slots_sel = 2'(ssel); cfg_width_sel = 2'(wsel);
    cfg_first_slot = 4'(first); cfg_own_count = 5'(cnt);
    cfg_fill_idle = fill; cfg_master = master;
    valid_pct = vp; pend_hs = 1'b0; q.delete(); cur_exp = '0;
    W = exp_width(wsel); N = 2 << ssel; L = W * N;
    repeat (3) @(negedge clk);
    chk("R1", 32'(sd_oe), 32'd0);
    chk("R1", 32'(sd_out), 32'd0);
    chk("R1", 32'(fsync_out), 32'd0);
    chk("R1", 32'(smp_ready), 32'd1);
    rst_n = 1'b1;
  endtask

  task automatic slave_run(input int frames);
    repeat (3) step(1'b0, -1);
    step(1'b1, -1);
    for (int f = 0; f < frames; f++) run_frame(L);
  endtask

  task automatic master_run(input int frames);
    for (int k = 1; k < L; k++) begin
      step(1'b0, -1);
      chk("R11", 32'(fsync_out), 32'(k == L-1));
    end
    for (int f = 0; f < frames; f++) run_frame(L);
  endtask

  initial begin
    #(8.0 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    // Directed: 4 slots x 16 bits (R7 truncation), slots 1..2 owned, released otherwise.
    setup(1, 0, 1, 2, 1'b0, 1'b0, 100); slave_run(3);
    // Directed: 16 slots x 32 bits, run clipped at slot 15, fill low elsewhere (R6, R7, R8).
    setup(3, 2, 14, 5, 1'b1, 1'b0, 100); slave_run(2);
    // Directed: sample stream absent, owned slots carry zeros (R10).
    setup(0, 1, 0, 2, 1'b0, 1'b0, 0); slave_run(3);
    // Directed: sync arriving mid-frame restarts at slot 0 (R3).
    setup(2, 1, 3, 3, 1'b0, 1'b0, 100); slave_run(1);
    run_frame(L/2 + 3); run_frame(L);
    // Directed: master mode with random fsync_in (R11).
    setup(2, 1, 2, 4, 1'b0, 1'b1, 100); master_run(2);
    // Random configurations.
    for (int t = 0; t < 16; t++) begin
      setup(int'($urandom % 4), int'($urandom % 4), int'($urandom % 16),
            int'($urandom % 17), 1'($urandom % 2), 1'(($urandom % 4) == 0), 85);
      if (cfg_master) master_run(2);
      else            slave_run(2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule